// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This block carries out the 32-bit atomic instruction group of a RISC-V core against a single-port, word-addressed data memory. The pipeline hands it an already decoded request: major opcode, the 5-bit operation selector, the address taken from rs1, the data taken from rs2, and a valid strobe. The unit answers with the value to be written to rd, a one-cycle completion pulse and an illegal-instruction flag.

Every accepted instruction runs the same two-phase sequence. In the first cycle the addressed word is read. In the second cycle the old word is available, the selected operator is applied, and the result is optionally written back. Load-reserved and store-conditional share this sequence. A single reservation register records which word a load-reserved touched. Each store-conditional uses that record to decide whether its write may proceed, and then clears it. The acquire/release ordering bits are not inputs and play no part.

Top module: `amo_unit`

## Requirements
- R1: While reset is applied and once it is released, `busy`, `done`, `illegal` and `mem_en` are 0.
- R2: A request is accepted only when `req_opcode` equals 0x2F and the unit is idle. Any other opcode produces no `done` and no memory access.
- R3: The legal selector values are 0x00 add, 0x01 swap, 0x02 load-reserved, 0x03 store-conditional, 0x04 xor, 0x08 or, 0x0C and, 0x10 signed min and 0x14 signed max. Any other value completes with `illegal`=1, `rd_result`=0, no memory access and no reservation change.
- R4: For an accepted request the word is read in the cycle after acceptance. `done` rises in the following cycle, together with any write to the same word index. `done` is therefore observed two cycles after the accepting edge.
- R5: Add, swap, xor, or and and return the old memory word in `rd_result`. They write op(old, rs2) to the same word, where swap writes rs2 unchanged.
- R6: Min and max compare the old word and rs2 as signed 32-bit values. They return the old word and write the smaller or larger value, respectively.
- R7: Load-reserved returns the addressed word, writes nothing, and records a valid reservation on the word index (address − base) >> 2. The low two address bits do not matter.
- R8: Store-conditional writes rs2 and returns 0 only if the reservation is valid and its index equals the addressed word index. Otherwise it writes nothing and returns 1. Fetch-and-op writes do not disturb the reservation.
- R9: Every in-window store-conditional clears the reservation, whether it succeeds or fails.
- R10: An address outside [MEM_BASE, MEM_BASE + 4·MEM_WORDS) completes with the same latency, `rd_result`=0, `illegal`=0, no memory access and no reservation change.
- R11: Requests presented while `busy` is 1, including during the completion cycle, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe |
| req_opcode | input | 7 | Major opcode of the instruction |
| req_funct5 | input | 5 | Operation selector (instruction bits 31:27) |
| req_addr | input | 32 | Byte address from rs1 |
| req_rs2 | input | 32 | Operand from rs2 |
| busy | output | 1 | A request is in progress |
| done | output | 1 | Completion pulse; result valid |
| illegal | output | 1 | Unsupported selector, valid with done |
| rd_result | output | 32 | Value for rd, valid with done |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 6 | Word index into the data memory |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after a read access |

## Verification
Two functions can coincide in one cycle. The write-back and completion of one instruction can meet the arrival of the next request. Likewise, a store-conditional can consult and clear the reservation in the same cycle that decides its write. The bench holds a second request high through the read and completion cycles of a running add and drops it before the unit returns to idle. It then checks that no second completion appears and that the other request's target word is untouched. Reservation sequences interleave load-reserved, fetch-and-op and store-conditional on equal and different words. They are judged against a bench-side memory and reservation model, with every memory word compared after each instruction.

// File: rtl/amo_pkg.sv
package amo_pkg;

  localparam logic [6:0] AMO_OPCODE = 7'h2F;

  localparam logic [4:0] F5_ADD  = 5'h00;
  localparam logic [4:0] F5_SWAP = 5'h01;
  localparam logic [4:0] F5_LR   = 5'h02;
  localparam logic [4:0] F5_SC   = 5'h03;
  localparam logic [4:0] F5_XOR  = 5'h04;
  localparam logic [4:0] F5_OR   = 5'h08;
  localparam logic [4:0] F5_AND  = 5'h0C;
  localparam logic [4:0] F5_MIN  = 5'h10;
  localparam logic [4:0] F5_MAX  = 5'h14;

  typedef enum logic [3:0] {
    OP_ADD, OP_SWAP, OP_LR, OP_SC, OP_XOR,
    OP_OR, OP_AND, OP_MIN, OP_MAX, OP_BAD
  } amo_op_e;

  typedef enum logic [1:0] {
    S_IDLE, S_RD, S_WB
  } amo_state_e;

endpackage

// File: rtl/amo_rst_sync.sv
module amo_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_ns = chain_q[STAGES-1];
endmodule

// File: rtl/amo_decode.sv
module amo_decode
  import amo_pkg::*;
(
  input  logic [4:0] funct5,
  output amo_op_e    op,
  output logic       legal
);
  always_comb begin
    legal = 1'b1;
    unique case (funct5)
      F5_ADD:  op = OP_ADD;
      F5_SWAP: op = OP_SWAP;
      F5_LR:   op = OP_LR;
      F5_SC:   op = OP_SC;
      F5_XOR:  op = OP_XOR;
      F5_OR:   op = OP_OR;
      F5_AND:  op = OP_AND;
      F5_MIN:  op = OP_MIN;
      F5_MAX:  op = OP_MAX;
      default: begin
        op    = OP_BAD;
        legal = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  amo_op_e         op,
  input  logic [XLEN-1:0] old_word,
  input  logic [XLEN-1:0] operand,
  output logic [XLEN-1:0] new_word
);
  logic old_lt;

  always_comb begin
    old_lt = $signed(old_word) < $signed(operand);
    case (op)
      OP_ADD:  new_word = old_word + operand;
      OP_XOR:  new_word = old_word ^ operand;
      OP_OR:   new_word = old_word | operand;
      OP_AND:  new_word = old_word & operand;
      OP_MIN:  new_word = old_lt ? old_word : operand;
      OP_MAX:  new_word = old_lt ? operand : old_word;
      default: new_word = operand;
    endcase
  end
endmodule

// File: rtl/amo_resv.sv
module amo_resv #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             hit_o
);
  logic             valid_q, valid_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    valid_d = valid_q;
    idx_d   = idx_q;
    if (set_i) begin
      valid_d = 1'b1;
      idx_d   = idx_i;
    end else if (clr_i) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      valid_q <= valid_d;
      if (set_i) idx_q <= idx_d;
    end
  end

  assign hit_o = valid_q && (idx_q == idx_i);

  // R9
  resv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !hit_o);

  // R7
  resv_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> (valid_q && idx_q == $past(idx_i)));
endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int               XLEN      = 32,
  parameter logic [XLEN-1:0]  MEM_BASE  = 32'h0000_1000,
  parameter int               MEM_WORDS = 64,
  localparam int              IDX_W     = $clog2(MEM_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [6:0]       req_opcode,
  input  logic [4:0]       req_funct5,
  input  logic [XLEN-1:0]  req_addr,
  input  logic [XLEN-1:0]  req_rs2,
  output logic             busy,
  output logic             done,
  output logic             illegal,
  output logic [XLEN-1:0]  rd_result,
  output logic             mem_en,
  output logic             mem_we,
  output logic [IDX_W-1:0] mem_addr,
  output logic [XLEN-1:0]  mem_wdata,
  input  logic [XLEN-1:0]  mem_rdata
);
  localparam logic [XLEN:0] WIN_LO = {1'b0, MEM_BASE};
  localparam logic [XLEN:0] WIN_HI = WIN_LO + (XLEN+1)'(MEM_WORDS * 4);

  logic rst_ns;
  amo_rst_sync #(.STAGES(2)) i_rst (.clk(clk), .rst_n(rst_n), .rst_ns(rst_ns));

  // request decode
  amo_op_e         dec_op;
  logic            dec_legal;
  logic [XLEN-1:0] addr_off;
  logic            in_win;
  logic            accept;
  logic            unused_addr;

  amo_decode i_dec (.funct5(req_funct5), .op(dec_op), .legal(dec_legal));

  always_comb begin
    addr_off = req_addr - MEM_BASE;
    in_win   = ({1'b0, req_addr} >= WIN_LO) && ({1'b0, req_addr} < WIN_HI);
  end
  assign unused_addr = ^{addr_off[1:0], addr_off[XLEN-1:IDX_W+2]};

  // state registers
  amo_state_e       state_q, state_d;
  amo_op_e          op_q;
  logic [IDX_W-1:0] idx_q;
  logic [XLEN-1:0]  rs2_q;
  logic             skip_q, skip_d;
  logic             bad_q, bad_d;

  assign accept = (state_q == S_IDLE) && req_valid && (req_opcode == AMO_OPCODE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:  if (accept) state_d = S_RD;
      S_RD:    state_d = S_WB;
      S_WB:    state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
    skip_d = !dec_legal || !in_win;
    bad_d  = !dec_legal;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= S_IDLE;
      op_q    <= OP_BAD;
      idx_q   <= '0;
      rs2_q   <= '0;
      skip_q  <= 1'b0;
      bad_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        op_q   <= dec_op;
        idx_q  <= addr_off[IDX_W+1:2];
        rs2_q  <= req_rs2;
        skip_q <= skip_d;
        bad_q  <= bad_d;
      end
    end
  end

  // write-back phase
  logic            in_wb, resv_hit, resv_set, resv_clr, wr_en;
  logic [XLEN-1:0] alu_out;

  amo_alu #(.XLEN(XLEN)) i_alu (
    .op(op_q), .old_word(mem_rdata), .operand(rs2_q), .new_word(alu_out));

  amo_resv #(.IDX_W(IDX_W)) i_resv (
    .clk(clk), .rst_n(rst_ns), .set_i(resv_set), .clr_i(resv_clr),
    .idx_i(idx_q), .hit_o(resv_hit));

  always_comb begin
    in_wb    = (state_q == S_WB) && !skip_q;
    resv_set = in_wb && (op_q == OP_LR);
    resv_clr = in_wb && (op_q == OP_SC);
    wr_en    = in_wb && (op_q != OP_LR) && ((op_q != OP_SC) || resv_hit);
    if (skip_q)             rd_result = '0;
    else if (op_q == OP_SC) rd_result = resv_hit ? '0 : XLEN'(1);
    else                    rd_result = mem_rdata;
  end

  assign busy      = (state_q != S_IDLE);
  assign done      = (state_q == S_WB);
  assign illegal   = done && bad_q;
  assign mem_en    = ((state_q == S_RD) && !skip_q) || wr_en;
  assign mem_we    = wr_en;
  assign mem_addr  = idx_q;
  assign mem_wdata = (op_q == OP_SC) ? rs2_q : alu_out;

  // R4
  rd_then_wb_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (mem_en && !mem_we) |=> done);

  // R3
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    illegal |-> (done && !mem_en && rd_result == '0));

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    done |=> !busy);

  // R8
  sc_zero_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (done && mem_we && op_q == OP_SC) |-> (rd_result == '0 && mem_wdata == rs2_q));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_ns |-> (!busy && !done && !mem_en));
endmodule

// File: tb/test_amo_unit.sv
`timescale 1ns/1ps
module test_amo_unit;
  localparam logic [31:0] BASE  = 32'h0000_1000;
  localparam int          WORDS = 64;

  logic        clk, rst_n, req_valid;
  logic [6:0]  req_opcode;
  logic [4:0]  req_funct5;
  logic [31:0] req_addr, req_rs2, rd_result, mem_wdata, mem_rdata;
  logic        busy, done, illegal, mem_en, mem_we;
  logic [5:0]  mem_addr;

  int checks = 0;
  int errors = 0;

  amo_unit #(.XLEN(32), .MEM_BASE(BASE), .MEM_WORDS(WORDS)) i_amo_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_opcode(req_opcode),
    .req_funct5(req_funct5), .req_addr(req_addr), .req_rs2(req_rs2),
    .busy(busy), .done(done), .illegal(illegal), .rd_result(rd_result),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // bench-side memory and model
  logic [31:0] mem [WORDS];
  logic [31:0] ref_mem [WORDS];
  logic        ref_rv;
  logic [5:0]  ref_ridx;

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic mem_chk(input string tag);
    int bad = 0;
    int first = -1;
    for (int i = 0; i < WORDS; i++)
      if (mem[i] !== ref_mem[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    if (first < 0) chk(1'b1, tag, "memory", 0, 0);
    else chk(1'b0, tag, $sformatf("memory word %0d", first), mem[first], ref_mem[first]);
  endtask

  // results of one request
  bit          g_done, g_ill, g_wr;
  int          g_lat;
  logic [31:0] g_res, g_wdata;
  logic [5:0]  g_widx;

  task automatic run_req(input logic [6:0] opc, input logic [4:0] f5,
                         input logic [31:0] addr, input logic [31:0] rs2);
    @(negedge clk);
    req_valid = 1'b1; req_opcode = opc; req_funct5 = f5;
    req_addr = addr; req_rs2 = rs2;
    @(negedge clk);
    req_valid = 1'b0;
    g_done = 1'b0; g_lat = 0; g_ill = 1'b0; g_wr = 1'b0;
    g_res = '0; g_wdata = '0; g_widx = '0;
    for (int k = 1; k <= 4; k++) begin
      if (!g_done && done) begin
        g_done = 1'b1; g_lat = k; g_res = rd_result; g_ill = illegal;
        g_wr = mem_we; g_wdata = mem_wdata; g_widx = mem_addr;
      end
      @(negedge clk);
    end
  endtask

  function automatic bit f5_legal(input logic [4:0] f5);
    return f5 inside {5'h00, 5'h01, 5'h02, 5'h03, 5'h04, 5'h08, 5'h0C, 5'h10, 5'h14};
  endfunction

  function automatic string tag_of(input logic [4:0] f5);
    if (!f5_legal(f5))                 return "R3";
    if (f5 == 5'h02)                   return "R7";
    if (f5 == 5'h03)                   return "R8";
    if (f5 == 5'h10 || f5 == 5'h14)    return "R6";
    return "R5";
  endfunction

  // model one instruction, compare against observed
  task automatic op_chk(input string tag, input logic [4:0] f5,
                        input logic [31:0] addr, input logic [31:0] rs2);
    bit          win, legal, e_wr;
    logic [5:0]  idx;
    logic [31:0] old, e_res, e_wdata, off;
    off   = addr - BASE;
    win   = (addr >= BASE) && ({1'b0, addr} < {1'b0, BASE} + 33'(WORDS * 4));
    idx   = off[7:2];
    legal = f5_legal(f5);
    e_wr = 1'b0; e_res = '0; e_wdata = '0;
    if (legal && win) begin
      old = ref_mem[idx];
      case (f5)
        5'h02: begin e_res = old; ref_rv = 1'b1; ref_ridx = idx; end
        5'h03: begin
          if (ref_rv && ref_ridx == idx) begin e_wr = 1'b1; e_wdata = rs2; e_res = 0; end
          else e_res = 1;
          ref_rv = 1'b0;
        end
        default: begin
          e_res = old; e_wr = 1'b1;
          case (f5)
            5'h00: e_wdata = old + rs2;
            5'h01: e_wdata = rs2;
            5'h04: e_wdata = old ^ rs2;
            5'h08: e_wdata = old | rs2;
            5'h0C: e_wdata = old & rs2;
            5'h10: e_wdata = ($signed(old) < $signed(rs2)) ? old : rs2;
            default: e_wdata = ($signed(old) > $signed(rs2)) ? old : rs2;
          endcase
        end
      endcase
      if (e_wr) ref_mem[idx] = e_wdata;
    end
    run_req(7'h2F, f5, addr, rs2);
    chk(g_done, tag, "done seen", 32'(g_done), 1);
    chk(g_lat == 2, "R4", "latency", g_lat, 2);
    chk(g_res === e_res, tag, $sformatf("rd f5=%h", f5), g_res, e_res);
    chk(g_ill == !legal, tag, "illegal flag", 32'(g_ill), 32'(!legal));
    chk(g_wr == e_wr, tag, "write enable", 32'(g_wr), 32'(e_wr));
    if (e_wr) chk(g_wdata === e_wdata && g_widx == idx, tag, "write data",
                  g_wdata, e_wdata);
    mem_chk(tag);
  endtask

  logic [31:0] vals [8];

  initial begin
    req_valid = 0; req_opcode = 0; req_funct5 = 0; req_addr = 0; req_rs2 = 0;
    rst_n = 0; ref_rv = 0; ref_ridx = 0;
    for (int i = 0; i < WORDS; i++) begin
      mem[i] = 32'h9E37_79B9 * (i + 1);
      ref_mem[i] = mem[i];
    end
    vals[0] = 0; vals[1] = 1; vals[2] = 32'hFFFF_FFFF; vals[3] = 32'h7FFF_FFFF;
    vals[4] = 32'h8000_0000; vals[5] = 32'h1234_5678; vals[6] = 32'hFFFF_FFFE;
    vals[7] = 5;
    repeat (3) @(negedge clk);
    // R1: quiet during reset
    chk(!busy && !done && !illegal && !mem_en, "R1", "outputs in reset",
        {busy, done, illegal, mem_en}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !illegal && !mem_en, "R1", "outputs after reset",
        {busy, done, illegal, mem_en}, 0);

    // R2: wrong opcodes ignored
    foreach (vals[j]) begin
      run_req(7'h33 ^ 7'(j), 5'h00, BASE + 32'(4 * j), 32'h1);
      chk(!g_done, "R2", "no done for foreign opcode", 32'(g_done), 0);
      mem_chk("R2");
    end

    // selector sweep (R3, R5, R6, R7, R8)
    for (int f = 0; f < 32; f++)
      op_chk(tag_of(5'(f)), 5'(f), BASE + 32'(4 * (f % 16)), 32'hA5A5_0000 + 32'(f));

    // operator sweep: set old via swap, then apply op (R5, R6)
    for (int o = 0; o < 9; o++) begin
      logic [4:0] f5;
      case (o)
        0: f5 = 5'h00; 1: f5 = 5'h01; 2: f5 = 5'h04; 3: f5 = 5'h08;
        4: f5 = 5'h0C; 5: f5 = 5'h10; 6: f5 = 5'h14; 7: f5 = 5'h10;
        default: f5 = 5'h14;
      endcase
      foreach (vals[a]) foreach (vals[b]) begin
        op_chk("R5", 5'h01, BASE + 32'h20, vals[a]);
        op_chk(tag_of(f5), f5, BASE + 32'h20, vals[b]);
      end
    end

    // reservation sequences
    op_chk("R8", 5'h03, BASE + 32'h30, 32'h1111);          // no reservation: fail
    op_chk("R7", 5'h02, BASE + 32'h0C, 0);
    op_chk("R8", 5'h03, BASE + 32'h10, 32'h2222);          // other word: fail
    op_chk("R9", 5'h03, BASE + 32'h0C, 32'h3333);          // cleared by previous SC
    op_chk("R7", 5'h02, BASE + 32'h0C, 0);
    op_chk("R8", 5'h00, BASE + 32'h0C, 32'h10);            // AMO keeps reservation
    op_chk("R8", 5'h03, BASE + 32'h0C, 32'h4444);          // success
    op_chk("R9", 5'h03, BASE + 32'h0C, 32'h5555);          // cleared after success
    op_chk("R7", 5'h02, BASE + 32'h14, 0);
    op_chk("R7", 5'h02, BASE + 32'h18, 0);                 // moves reservation
    op_chk("R8", 5'h03, BASE + 32'h14, 32'h6666);          // old word: fail
    op_chk("R7", 5'h02, BASE + 32'h1E, 0);                 // low bits ignored
    op_chk("R7", 5'h03, BASE + 32'h1D, 32'h7777);          // same word: success

    // out-of-window (R10)
    op_chk("R7", 5'h02, BASE + 32'h08, 0);
    op_chk("R10", 5'h01, BASE - 4, 32'hDEAD);
    op_chk("R10", 5'h03, BASE + 32'(WORDS * 4), 32'hBEEF);  // reservation kept
    op_chk("R10", 5'h00, 32'h0, 32'h1);
    op_chk("R10", 5'h03, BASE + 32'h08, 32'hCAFE);          // still succeeds

    // busy: second request held through read and completion (R11)
    begin
      logic [31:0] e_old;
      e_old = ref_mem[10];
      ref_mem[10] = e_old + 3;
      @(negedge clk);
      req_valid = 1; req_opcode = 7'h2F; req_funct5 = 5'h00;
      req_addr = BASE + 32'h28; req_rs2 = 3;
      @(negedge clk);
      req_funct5 = 5'h01; req_addr = BASE + 32'h2C; req_rs2 = 32'hDEAD_0000;
      @(negedge clk);
      chk(done && rd_result === e_old, "R11", "first op result", rd_result, e_old);
      @(negedge clk);
      req_valid = 0;
      for (int k = 0; k < 3; k++) begin
        chk(!done && !mem_en, "R11", "no second op", {done, mem_en}, 0);
        @(negedge clk);
      end
      mem_chk("R11");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule